// File: doc/BRIEF.md
# Push-Button Electronic Dice Controller

This block turns one push-button into a six-sided dice display. While the button is held, a face counter steps through the values 1 to 6 once per system clock and wraps back to 1. When the button is released, the counter keeps its value and that face stays on the display. The counter runs at full clock speed, so how long a person holds the button gives no useful hint about where it will stop.

The seven pip LEDs of a dice face form four groups that always light together. These are the centre pip, one diagonal pair, the other diagonal pair and the pair at the sides of the middle row. The block drives one enable per group and also outputs the 3-bit face value.

The button passes through a flop-chain synchronizer before it gates the counter. The gating is a synchronous count enable, not a gated clock. The group enables are registered from the counter's next value, so they change on the same clock edge as the face they show.

Top module: `dice_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released with the button up, the face output is 1 and only the centre group is lit (pip vector {centre, diag_a, diag_b, side} = 4'b1000).
- R2: For each rising edge on which the synchronized button is high, the face advances by one step in the order 1, 2, 3, 4, 5, 6, 1, ...
- R3: After reset, the face output never shows the values 0 or 7.
- R4: While the synchronized button is low, the face output and all four group enables hold their values.
- R5: A button press that first becomes visible before rising edge k produces its first step on edge k+2. A release that becomes visible before edge m still produces a step on edge m+1 and none after it. The number of steps therefore equals the number of edges on which the raw button was high.
- R6: The centre group enable equals face bit 0.
- R7: The first diagonal group enable equals face bit 1 OR face bit 2 (lit on faces 2 to 6).
- R8: The second diagonal group enable equals face bit 2 (lit on faces 4, 5 and 6).
- R9: The side group enable equals face bit 1 AND face bit 2, so it is lit on face 6 only.
- R10: The group enables change on the same clock edge as the face output and match the face shown in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter steps on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Raw push-button level, high while pressed, asynchronous to clk |
| face_o | output | 3 | Face value currently shown, 1 to 6 |
| pip_mid_o | output | 1 | Centre pip enable |
| pip_diag_a_o | output | 1 | Enable of the first diagonal pip pair |
| pip_diag_b_o | output | 1 | Enable of the second diagonal pip pair |
| pip_side_o | output | 1 | Enable of the middle-row side pip pair |

## Verification
A button level set between edges reaches the counter's enable two edges later, and the first step shows on the third rising edge. Each task therefore drives the button away from the active edge, counts the edges on which it was high, and compares the face four cycles after release, when all steps have landed. The latency scenario samples after each of the first three edges of a press: the face is unchanged after two edges and has moved after the third. A per-cycle monitor compares the four group enables with the face shown in that same cycle, using a face-to-pattern table.

// File: rtl/dice_pkg.sv
package dice_pkg;

    localparam int FACE_W   = 3;
    localparam int FACE_LO  = 1;
    localparam int FACE_HI  = 6;

    typedef logic [FACE_W-1:0] face_t;

    localparam face_t FACE_FIRST = face_t'(FACE_LO);
    localparam face_t FACE_LAST  = face_t'(FACE_HI);

    // Group enables of the seven pips, packed as {mid, diag_a, diag_b, side}.
    typedef struct packed {
        logic mid;
        logic diag_a;
        logic diag_b;
        logic side;
    } pips_t;

    localparam pips_t PIPS_FIRST = '{mid: 1'b1, diag_a: 1'b0, diag_b: 1'b0, side: 1'b0};

    // Successor of a face; any value outside 1..6 falls back to 1.
    function automatic face_t face_next(input face_t f);
        face_t r;
        if ((f >= FACE_LAST) || (f < FACE_FIRST)) begin
            r = FACE_FIRST;
        end else begin
            r = f + face_t'(1);
        end
        return r;
    endfunction

    // Boolean pip equations on face bits {c, b, a}.
    function automatic pips_t face_to_pips(input face_t f);
        pips_t p;
        p.mid    = f[0];
        p.diag_a = f[1] | f[2];
        p.diag_b = f[2];
        p.side   = f[1] & f[2];
        return p;
    endfunction

endpackage

// File: rtl/dice_btn_sync.sv
module dice_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d;
    sync_st_t st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = async_i;
            end
        end else begin : g_chain
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/dice_face_ctr.sv
module dice_face_ctr
    import dice_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_en,
    output face_t face_nxt_o,
    output face_t face_o
);

    typedef struct packed {
        face_t face;
    } ctr_st_t;

    localparam ctr_st_t CTR_RST = '{face: FACE_FIRST};

    ctr_st_t st_d;
    ctr_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            st_d.face = face_next(st_q.face);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign face_nxt_o = st_d.face;
    assign face_o     = st_q.face;

endmodule

// File: rtl/dice_pip_reg.sv
module dice_pip_reg
    import dice_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  face_t face_nxt_i,
    output pips_t pips_o
);

    typedef struct packed {
        pips_t pips;
    } pip_st_t;

    localparam pip_st_t PIP_RST = '{pips: PIPS_FIRST};

    pip_st_t st_d;
    pip_st_t st_q;

    // Decode the face that the counter loads on this edge, so both
    // registers update together.
    always_comb begin
        st_d      = st_q;
        st_d.pips = face_to_pips(face_nxt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PIP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pips_o = st_q.pips;

endmodule

// File: rtl/dice_ctrl.sv
module dice_ctrl
    import dice_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 btn_i,
    output logic [FACE_W-1:0]    face_o,
    output logic                 pip_mid_o,
    output logic                 pip_diag_a_o,
    output logic                 pip_diag_b_o,
    output logic                 pip_side_o
);

    logic  roll_en;
    face_t face_nxt;
    face_t face_cur;
    pips_t pips;

    dice_btn_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (btn_i),
        .sync_o  (roll_en)
    );

    dice_face_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (roll_en),
        .face_nxt_o (face_nxt),
        .face_o     (face_cur)
    );

    dice_pip_reg u_pips (
        .clk        (clk),
        .rst_n      (rst_n),
        .face_nxt_i (face_nxt),
        .pips_o     (pips)
    );

    assign face_o       = face_cur;
    assign pip_mid_o    = pips.mid;
    assign pip_diag_a_o = pips.diag_a;
    assign pip_diag_b_o = pips.diag_b;
    assign pip_side_o   = pips.side;

endmodule

// File: rtl/dice_ctrl_chk.sv
module dice_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       roll_en,
    input logic [2:0] face,
    input logic       mid,
    input logic       diag_a,
    input logic       diag_b,
    input logic       side
);

    AST_FACE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (face >= 3'd1) && (face <= 3'd6)); // R3

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        roll_en |=> (face == (($past(face) == 3'd6) ? 3'd1 : $past(face) + 3'd1))); // R2

    AST_HOLD_FACE: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_en |=> $stable(face)); // R4

    AST_HOLD_PIPS: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_en |=> $stable({mid, diag_a, diag_b, side})); // R4

    AST_MID_PIP: assert property (@(posedge clk) disable iff (!rst_n)
        mid == face[0]); // R6

    AST_DIAG_A_PIP: assert property (@(posedge clk) disable iff (!rst_n)
        diag_a == (face[1] | face[2])); // R7

    AST_DIAG_B_PIP: assert property (@(posedge clk) disable iff (!rst_n)
        diag_b == face[2]); // R8

    AST_SIDE_SIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        side |-> (face == 3'd6)); // R9

    AST_PIPS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (face != $past(face)) |-> ({mid, diag_a, diag_b, side} != $past({mid, diag_a, diag_b, side}))); // R10

endmodule

bind dice_ctrl dice_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .roll_en (roll_en),
    .face    (face_o),
    .mid     (pip_mid_o),
    .diag_a  (pip_diag_a_o),
    .diag_b  (pip_diag_b_o),
    .side    (pip_side_o)
);

// File: tb/sim_dice_ctrl.sv
`timescale 1ns/1ps
module sim_dice_ctrl;

    logic       clk;
    logic       rst_n;
    logic       btn;
    logic [2:0] face;
    logic       p_mid;
    logic       p_da;
    logic       p_db;
    logic       p_side;

    int checks;
    int errors;
    int exp_face;
    bit mon_on;
    bit done;

    dice_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_i        (btn),
        .face_o       (face),
        .pip_mid_o    (p_mid),
        .pip_diag_a_o (p_da),
        .pip_diag_b_o (p_db),
        .pip_side_o   (p_side)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Face to {mid, diag_a, diag_b, side}, taken from the pip layout of each face.
    function automatic logic [3:0] pattern_of(input int f);
        case (f)
            1: return 4'b1000;
            2: return 4'b0100;
            3: return 4'b1100;
            4: return 4'b0110;
            5: return 4'b1110;
            6: return 4'b0111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int step_face(input int f, input int n);
        return ((f - 1 + n) % 6) + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_face_pips(input string req);
        chk({req, " face"}, int'(face), exp_face);
        chk({req, " pips"}, int'({p_mid, p_da, p_db, p_side}), int'(pattern_of(exp_face)));
    endtask

    // Hold the button for n rising edges, then wait until every step has landed.
    task automatic press(input int n);
        @(negedge clk);
        btn = 1'b1;
        repeat (n) @(negedge clk);
        btn = 1'b0;
        repeat (4) @(negedge clk);
        exp_face = step_face(exp_face, n);
    endtask

    // R3 and R10: every cycle, the face is legal and the enables match it.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            chk("R3 legal face", int'((face >= 3'd1) && (face <= 3'd6)), 1);
            chk("R10 pips match face", int'({p_mid, p_da, p_db, p_side}),
                int'(pattern_of(int'(face))));
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        btn   = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 face in reset", int'(face), 1);
        chk("R1 pips in reset", int'({p_mid, p_da, p_db, p_side}), 4'b1000);
        btn = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        exp_face = 1;
        chk_face_pips("R1 after reset");
    endtask

    task automatic t_single_steps();
        for (int i = 0; i < 6; i++) begin
            press(1);
            chk_face_pips("R2 R6 R7 R8 R9 single step");
        end
    endtask

    task automatic t_latency();
        int start;
        start = exp_face;
        @(negedge clk);
        btn = 1'b1;
        @(negedge clk);
        chk("R5 no step after edge 1", int'(face), start);
        @(negedge clk);
        chk("R5 no step after edge 2", int'(face), start);
        @(negedge clk);
        chk("R5 step on edge 3", int'(face), step_face(start, 1));
        btn = 1'b0;
        @(negedge clk);
        chk("R5 step after release edge 1", int'(face), step_face(start, 2));
        @(negedge clk);
        chk("R5 step after release edge 2", int'(face), step_face(start, 3));
        repeat (3) @(negedge clk);
        exp_face = step_face(start, 3);
        chk_face_pips("R5 steps equal held edges");
    endtask

    task automatic t_hold();
        logic [3:0] pips0;
        pips0 = {p_mid, p_da, p_db, p_side};
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 10 == 9) begin
                chk("R4 face held", int'(face), exp_face);
                chk("R4 pips held", int'({p_mid, p_da, p_db, p_side}), int'(pips0));
            end
        end
    endtask

    task automatic t_full_turn();
        int start;
        start = exp_face;
        press(6);
        chk("R2 six steps return", int'(face), start);
        chk_face_pips("R2 full turn");
    endtask

    task automatic t_long_holds();
        press(100);
        chk_face_pips("R2 hold 100");
        press(7);
        chk_face_pips("R2 hold 7");
        press(1001);
        chk_face_pips("R2 hold 1001");
    endtask

    task automatic t_reset_mid();
        press(3);
        @(negedge clk);
        btn = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset face", int'(face), 1);
        btn = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        exp_face = 1;
        chk_face_pips("R1 after mid-run reset");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        checks   = 0;
        errors   = 0;
        exp_face = 1;
        mon_on   = 1'b0;
        done     = 1'b0;
        rst_n    = 1'b0;
        btn      = 1'b0;
        t_reset();
        mon_on = 1'b1;
        t_single_steps();
        t_latency();
        t_hold();
        t_full_turn();
        t_long_holds();
        t_hold();
        t_reset_mid();
        finish_run();
    end

endmodule